// File: doc/BRIEF.md
# Ethernet Frame Statistics Counter Bank

This block holds the event counters that a fast Ethernet MAC keeps for network management. The transmit engine and the receive engine each raise a one-cycle completion strobe when a frame is finished on the link, with a small set of outcome flags alongside it. The bank turns each strobe into increments of the matching counters. A frame that is only fetched or only partly received changes nothing. Every counter stops at its all-ones value instead of wrapping.

Software asks for the counters through a one-cycle command with a one-bit code. The block then streams every counter, lowest ID first, as one word per valid/ready handshake. A final completion word carries the `dump_last` flag. A dump-and-reset command clears each counter in the same cycle that its value is captured for output. An event that lands in that cycle is not lost: the counter then holds 1. A command that arrives while a dump is in progress is dropped.

Counter IDs, with the default of two flags per direction: 0 transmit good, 1 transmit excess-collision abort, 2 transmit late-collision abort, 3 receive good, 4 receive CRC error, 5 receive alignment error.

Top module: `stat_counter_bank`

## Requirements
- R1: A transmit strobe (`tx_done`=1) with `tx_flags`=0 adds one to counter ID 0 (transmit good) and to no other counter.
- R2: A transmit strobe with `tx_flags` bit 0 set adds one to ID 1 (excess collisions), and with bit 1 set adds one to ID 2 (late collision). Each set bit counts, and ID 0 is not incremented when any flag is set.
- R3: A receive strobe (`rx_done`=1) with `rx_flags`=0 adds one to ID 3 (receive good). With `rx_flags` bit 0 set it adds one to ID 4 (CRC error), and with bit 1 set it adds one to ID 5 (alignment error).
- R4: Counters change only on a completion strobe or a dump-and-reset capture. Flags presented without their strobe are ignored.
- R5: A counter at all ones stays at all ones on further events; it never wraps.
- R6: `cmd_valid` while idle starts a dump. In the next cycle `dump_valid` is high with ID 0. Each accepted word is followed by the next ID in ascending order. After the last ID comes one word equal to `MARK_WORD` with `dump_last`=1.
- R7: While `dump_valid` is high and `dump_ready` is low, `dump_valid`, `dump_data` and `dump_last` hold their values.
- R8: `cmd_code`=0 dumps without changing any counter. `cmd_code`=1 clears each counter in the cycle its value is captured (the cycle the command is taken for ID 0, otherwise the cycle the previous word is accepted). An event in that cycle leaves the counter at 1. The word that is output is the value from before the clear.
- R9: `busy` rises the cycle after a command is taken and falls the cycle after the completion word is accepted. `cmd_valid` is ignored while `busy` is high.
- R10: After reset every counter is 0, and `dump_valid` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tx_done | input | 1 | Transmit frame finished on the link (one cycle per frame) |
| tx_flags | input | TX_FLAG_W | Transmit outcome flags: bit 0 excess collisions, bit 1 late collision |
| rx_done | input | 1 | Receive frame finished (one cycle per frame) |
| rx_flags | input | RX_FLAG_W | Receive outcome flags: bit 0 CRC error, bit 1 alignment error |
| cmd_valid | input | 1 | Dump command strobe |
| cmd_code | input | 1 | 0 dump only, 1 dump and reset |
| dump_ready | input | 1 | Consumer accepts the current word |
| dump_valid | output | 1 | A dump word is presented |
| dump_data | output | CNT_W | Counter value or completion word |
| dump_last | output | 1 | Current word is the completion word |
| busy | output | 1 | Dump in progress |

## Verification
The assertions assume that the consumer only changes `dump_ready` as a plain acceptance signal, and that strobes and flags are valid on every cycle after reset, with no X values. Given that, they check that counters stay quiet when the block is idle with no strobes and no command. The stimulus keeps to this by driving every input at the falling clock edge from known values. Commands are issued at random, including while a dump is already running, so the dropping of such commands is exercised. The bench narrows the counters to six bits so that saturation is reached within a short run.

// File: rtl/stat_bank_pkg.sv
package stat_bank_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_WORD = 2'd1,
    SEQ_MARK = 2'd2
  } seq_state_e;

  localparam logic CMD_DUMP       = 1'b0;
  localparam logic CMD_DUMP_CLEAR = 1'b1;
endpackage

// File: rtl/stat_rst_sync.sv
module stat_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_n_sync = out_q;
endmodule

// File: rtl/stat_event_decode.sv
// Turns one completion strobe plus its flags into per-counter increments.
// Bit 0 of the result is the "good" counter, bit 1+k follows flag k.
module stat_event_decode #(
  parameter int FLAG_W = 2
) (
  input  logic              done,
  input  logic [FLAG_W-1:0] flags,
  output logic [FLAG_W:0]   inc
);
  always_comb begin
    inc[0] = done && (flags == '0);
    for (int k = 0; k < FLAG_W; k++) begin
      inc[k+1] = done && flags[k];
    end
  end
endmodule

// File: rtl/stat_sat_counter.sv
module stat_sat_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] TOP = '1;
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = inc || clr;
    if (clr) begin
      cnt_d = inc ? ONE : '0;
    end else if (inc && (cnt_q != TOP)) begin
      cnt_d = cnt_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign q = cnt_q;
endmodule

// File: rtl/stat_dump_seq.sv
module stat_dump_seq
  import stat_bank_pkg::*;
#(
  parameter int           NUM       = 6,
  parameter int           W         = 32,
  parameter logic [W-1:0] MARK_WORD = '1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_valid,
  input  logic                    cmd_code,
  input  logic                    out_ready,
  input  logic [W-1:0]            cap_data,
  output logic                    cap_fire,
  output logic                    cap_clr,
  output logic [$clog2(NUM)-1:0]  cap_idx,
  output logic                    out_valid,
  output logic [W-1:0]            out_data,
  output logic                    out_last,
  output logic                    busy
);
  localparam int                 IDX_W = $clog2(NUM);
  localparam logic [IDX_W-1:0]   LAST  = IDX_W'(NUM - 1);
  localparam logic [IDX_W-1:0]   STEP  = IDX_W'(1);

  seq_state_e       st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             mode_q, mode_d;
  logic [W-1:0]     data_q, data_d;
  logic             hs;

  assign hs = out_valid && out_ready;

  always_comb begin
    st_d     = st_q;
    idx_d    = idx_q;
    mode_d   = mode_q;
    data_d   = data_q;
    cap_fire = 1'b0;
    cap_idx  = idx_q;
    cap_clr  = 1'b0;
    unique case (st_q)
      SEQ_IDLE: begin
        if (cmd_valid) begin
          st_d     = SEQ_WORD;
          idx_d    = '0;
          mode_d   = cmd_code;
          cap_fire = 1'b1;
          cap_idx  = '0;
          cap_clr  = (cmd_code == CMD_DUMP_CLEAR);
          data_d   = cap_data;
        end
      end
      SEQ_WORD: begin
        if (hs) begin
          if (idx_q == LAST) begin
            st_d   = SEQ_MARK;
            data_d = MARK_WORD;
          end else begin
            idx_d    = idx_q + STEP;
            cap_fire = 1'b1;
            cap_idx  = idx_q + STEP;
            cap_clr  = (mode_q == CMD_DUMP_CLEAR);
            data_d   = cap_data;
          end
        end
      end
      SEQ_MARK: begin
        if (hs) begin
          st_d = SEQ_IDLE;
        end
      end
      default: st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      idx_q  <= '0;
      mode_q <= 1'b0;
      data_q <= '0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      mode_q <= mode_d;
      data_q <= data_d;
    end
  end

  assign out_valid = (st_q != SEQ_IDLE);
  assign out_last  = (st_q == SEQ_MARK);
  assign out_data  = data_q;
  assign busy      = (st_q != SEQ_IDLE);
endmodule

// File: rtl/stat_counter_bank.sv
module stat_counter_bank #(
  parameter int               CNT_W     = 32,
  parameter int               TX_FLAG_W = 2,
  parameter int               RX_FLAG_W = 2,
  parameter logic [CNT_W-1:0] MARK_WORD = '1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tx_done,
  input  logic [TX_FLAG_W-1:0] tx_flags,
  input  logic                 rx_done,
  input  logic [RX_FLAG_W-1:0] rx_flags,
  input  logic                 cmd_valid,
  input  logic                 cmd_code,
  input  logic                 dump_ready,
  output logic                 dump_valid,
  output logic [CNT_W-1:0]     dump_data,
  output logic                 dump_last,
  output logic                 busy
);
  localparam int TX_CNT  = TX_FLAG_W + 1;
  localparam int RX_CNT  = RX_FLAG_W + 1;
  localparam int NUM_CNT = TX_CNT + RX_CNT;
  localparam int IDX_W   = $clog2(NUM_CNT);

  logic                     rst_n_int;
  logic [NUM_CNT-1:0]       inc_vec;
  logic [NUM_CNT*CNT_W-1:0] cnt_flat;
  logic                     cap_fire;
  logic                     cap_clr;
  logic [IDX_W-1:0]         cap_idx;
  logic [CNT_W-1:0]         cap_data;

  stat_rst_sync u_rst (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_n_sync (rst_n_int)
  );

  stat_event_decode #(.FLAG_W(TX_FLAG_W)) u_tx_dec (
    .done  (tx_done),
    .flags (tx_flags),
    .inc   (inc_vec[TX_CNT-1:0])
  );

  stat_event_decode #(.FLAG_W(RX_FLAG_W)) u_rx_dec (
    .done  (rx_done),
    .flags (rx_flags),
    .inc   (inc_vec[NUM_CNT-1:TX_CNT])
  );

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    logic clr_here;
    assign clr_here = cap_fire && cap_clr && (cap_idx == IDX_W'(g));
    stat_sat_counter #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n_int),
      .inc   (inc_vec[g]),
      .clr   (clr_here),
      .q     (cnt_flat[g*CNT_W +: CNT_W])
    );
  end

  assign cap_data = cnt_flat[cap_idx*CNT_W +: CNT_W];

  stat_dump_seq #(
    .NUM       (NUM_CNT),
    .W         (CNT_W),
    .MARK_WORD (MARK_WORD)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .out_ready (dump_ready),
    .cap_data  (cap_data),
    .cap_fire  (cap_fire),
    .cap_clr   (cap_clr),
    .cap_idx   (cap_idx),
    .out_valid (dump_valid),
    .out_data  (dump_data),
    .out_last  (dump_last),
    .busy      (busy)
  );
endmodule

// File: rtl/stat_counter_bank_chk.sv
module stat_counter_bank_chk #(
  parameter int NUM = 6,
  parameter int W   = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_done,
  input logic             rx_done,
  input logic             cmd_valid,
  input logic             dump_ready,
  input logic             dump_valid,
  input logic [W-1:0]     dump_data,
  input logic             dump_last,
  input logic             busy,
  input logic [NUM*W-1:0] cnt_flat
);
  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dump_valid && !dump_ready |=> dump_valid && $stable(dump_data) && $stable(dump_last));

  // R9
  busy_covers_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dump_valid |-> busy);

  // R9
  release_after_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dump_valid && dump_ready && dump_last |=> !busy);

  // R6
  mark_is_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dump_last |-> dump_valid);

  // R4
  quiet_counters_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_done && !rx_done && !busy && !cmd_valid |=> $stable(cnt_flat));

  for (genvar g = 0; g < NUM; g++) begin : g_sat
    // R5
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_flat[g*W +: W] == '1) && !busy && !cmd_valid |=> (cnt_flat[g*W +: W] == '1));
  end
endmodule

bind stat_counter_bank stat_counter_bank_chk #(.NUM(NUM_CNT), .W(CNT_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .tx_done    (tx_done),
  .rx_done    (rx_done),
  .cmd_valid  (cmd_valid),
  .dump_ready (dump_ready),
  .dump_valid (dump_valid),
  .dump_data  (dump_data),
  .dump_last  (dump_last),
  .busy       (busy),
  .cnt_flat   (cnt_flat)
);

// File: tb/stat_counter_bank_tb_top.sv
`timescale 1ns/1ps
module stat_counter_bank_tb_top;
  localparam int           W    = 6;
  localparam int           N    = 6;
  localparam logic [W-1:0] MARK = 6'h15;
  localparam int unsigned  MAXV = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         tx_done, rx_done, cmd_valid, cmd_code, dump_ready;
  logic [1:0]   tx_flags, rx_flags;
  logic         dump_valid, dump_last, busy;
  logic [W-1:0] dump_data;

  int    n_checks = 0;
  int    n_fail   = 0;
  string tag      = "R10";

  int unsigned  m [N];
  bit           mb, mv, ml, mmode;
  int           mi;
  logic [W-1:0] md;

  always #4 clk = ~clk;

  stat_counter_bank #(
    .CNT_W(W), .TX_FLAG_W(2), .RX_FLAG_W(2), .MARK_WORD(MARK)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .tx_done(tx_done), .tx_flags(tx_flags),
    .rx_done(rx_done), .rx_flags(rx_flags), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .dump_ready(dump_ready), .dump_valid(dump_valid),
    .dump_data(dump_data), .dump_last(dump_last), .busy(busy)
  );

  task automatic check(string t, string what, longint act, longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", t, what, act, exp);
    end
  endtask

  function automatic int unsigned sat_inc(int unsigned v);
    return (v == MAXV) ? v : v + 1;
  endfunction

  task automatic model_edge();
    bit inc [N];
    bit cap;
    int capi;
    inc[0] = tx_done && (tx_flags == 2'b00);
    inc[1] = tx_done && tx_flags[0];
    inc[2] = tx_done && tx_flags[1];
    inc[3] = rx_done && (rx_flags == 2'b00);
    inc[4] = rx_done && rx_flags[0];
    inc[5] = rx_done && rx_flags[1];
    cap = 1'b0;
    capi = 0;
    if (!mb) begin
      if (cmd_valid) begin
        mb = 1; mv = 1; ml = 0; mi = 0; mmode = cmd_code;
        md = W'(m[0]); cap = 1; capi = 0;
      end
    end else if (mv && dump_ready) begin
      if (ml) begin
        mb = 0; mv = 0; ml = 0;
      end else if (mi == N - 1) begin
        md = MARK; ml = 1;
      end else begin
        mi++; md = W'(m[mi]); cap = 1; capi = mi;
      end
    end
    for (int j = 0; j < N; j++) begin
      if (cap && mmode && (j == capi)) m[j] = inc[j] ? 1 : 0;
      else if (inc[j]) m[j] = sat_inc(m[j]);
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(tag, "busy (R9)", busy, mb);
    check(tag, "dump_valid (R6)", dump_valid, mv);
    if (mv) begin
      check(tag, "dump_data", dump_data, md);
      check(tag, "dump_last", dump_last, ml);
    end
  endtask

  task automatic idle_inputs();
    tx_done = 0; rx_done = 0; tx_flags = 0; rx_flags = 0;
    cmd_valid = 0; cmd_code = 0; dump_ready = 0;
  endtask

  task automatic tx_ev(logic [1:0] f);
    tx_done = 1; tx_flags = f; step(); tx_done = 0; tx_flags = 0;
  endtask

  task automatic rx_ev(logic [1:0] f);
    rx_done = 1; rx_flags = f; step(); rx_done = 0; rx_flags = 0;
  endtask

  task automatic dump(logic code, int ready_pct, bit busy_events);
    cmd_valid = 1; cmd_code = code; step();
    cmd_valid = 0;
    while (mb) begin
      dump_ready = (($urandom % 100) < ready_pct);
      if (busy_events) begin
        tx_done = $urandom % 2; tx_flags = 2'($urandom);
        rx_done = $urandom % 2; rx_flags = 2'($urandom);
        cmd_valid = $urandom % 2; cmd_code = $urandom % 2;
      end
      step();
    end
    idle_inputs();
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int j = 0; j < N; j++) m[j] = 0;
    mb = 0; mv = 0; ml = 0; mmode = 0; mi = 0; md = '0;
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10", "dump_valid", dump_valid, 0);
    check("R10", "busy", busy, 0);
    rst_n = 1;
    repeat (4) step();
    tag = "R10"; dump(0, 100, 0);

    // R1: good transmits
    tag = "R1";
    repeat (3) tx_ev(2'b00);
    dump(0, 100, 0);

    // R2: transmit abort flags, including both together
    tag = "R2";
    tx_ev(2'b01); tx_ev(2'b01); tx_ev(2'b10); tx_ev(2'b11);
    dump(0, 100, 0);

    // R3: receive outcomes
    tag = "R3";
    rx_ev(2'b00); rx_ev(2'b01); rx_ev(2'b10); rx_ev(2'b10); rx_ev(2'b11);
    dump(0, 100, 0);

    // R4: flags without strobe are ignored
    tag = "R4";
    tx_flags = 2'b11; rx_flags = 2'b11; repeat (5) step();
    idle_inputs();
    dump(0, 100, 0);

    // R7: back-pressure on the dump stream
    tag = "R7";
    dump(0, 30, 0);

    // R8: dump-and-reset with an event on the ID 0 capture cycle
    tag = "R8";
    tx_done = 1; tx_flags = 2'b00;
    dump(1, 60, 0);
    dump(0, 100, 0);

    // R5: saturation of transmit good
    tag = "R5";
    repeat (70) tx_ev(2'b00);
    dump(0, 100, 0);
    dump(0, 100, 0);

    // R9: commands and events arriving during a dump
    tag = "R9";
    dump(1, 50, 1);
    dump(0, 50, 1);

    // R6: random mix with dumps in both modes
    tag = "R6";
    for (int c = 0; c < 3000; c++) begin
      tx_done = (($urandom % 100) < 30); tx_flags = 2'($urandom);
      rx_done = (($urandom % 100) < 30); rx_flags = 2'($urandom);
      cmd_valid = (($urandom % 100) < 4); cmd_code = $urandom % 2;
      dump_ready = (($urandom % 100) < 70);
      step();
    end
    idle_inputs();
    dump_ready = 1;
    while (mb) step();
    dump(0, 100, 0);

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule